// File: doc/BRIEF.md
# External Bus Tenure Controller

This block manages bus ownership for one master on a shared external bus coordinated by a request line and an open-drain busy line. When internal logic needs the external bus, the block raises its request toward an external arbiter. It takes ownership only after it has seen a grant and an idle busy line at the same sampling edge. While it is the owner, it pulls the busy line low.

The block supports parking. An owner whose work is finished keeps the busy line asserted for as long as the grant remains, so it can start new transfers without another arbitration round. When the grant is withdrawn and no transfer is in progress, the block releases the line in two steps. It first drives the line high for one clock, then turns its driver off so that an external pull-up holds the level.

A software hold bit keeps the request asserted even when no transfer is needed. In stop or wait, the request drops unless the hold bit is set. If the hold bit is set, the request keeps its last value.

Top module: `bus_tenure_ctl`

## Requirements
- R1: `br_out` (1 = requesting) is a registered copy of `ext_need OR req_hold`, one clock later, whenever `stop_mode` and `wait_mode` are both 0. It does not depend on ownership.
- R2: With `req_hold` = 1 and `ext_need` = 0, outside stop and wait, `br_out` is 1 after the next clock.
- R3: If `stop_mode` or `wait_mode` is 1 at a clock edge, `br_out` becomes 0 when `req_hold` is 0 and keeps its previous value when `req_hold` is 1.
- R4: While `rst_n` is 0, `br_out` = 0, `is_master` = 0, `bb_oe` = 0 and `bb_drive` = 1. Reset acts at once, without waiting for a clock.
- R5: `arb_grant` and `bb_line` (1 = idle) are registered at each edge. `is_master` rises at the following edge only if both registered values were 1 and `ext_need` is 1 at that edge. Ownership therefore appears two edges after the inputs are first presented.
- R6: While `is_master` is 1, `bb_oe` = 1 and `bb_drive` = 0.
- R7: An owner stays owner while the registered grant is 1, even with `ext_need` = 0 (parked). It reuses the bus on a new need without re-arbitrating.
- R8: When `ext_need` is 0 and the registered grant is 0, ownership ends at the next edge. For exactly one clock after that, `bb_oe` = 1 and `bb_drive` = 1. Then `bb_oe` = 0.
- R9: An owner whose grant is withdrawn keeps ownership as long as `ext_need` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_need | input | 1 | Internal logic needs the external bus |
| arb_grant | input | 1 | Grant from the external arbiter |
| bb_line | input | 1 | Level of the busy line (0 = busy) |
| req_hold | input | 1 | Software request-hold bit |
| stop_mode | input | 1 | Stop state indication |
| wait_mode | input | 1 | Wait state indication |
| br_out | output | 1 | Bus request (1 = requesting), always driven |
| bb_drive | output | 1 | Value driven on the busy line |
| bb_oe | output | 1 | Busy line driver enable |
| is_master | output | 1 | Block owns the external bus |

## Verification
A corrupted ownership state is visible at the ports on the next clock. Both `is_master` and the busy-line pair `bb_oe`/`bb_drive` change together, so an early take, a lost park or a missing release shows up within one cycle. A fault in the two sampling registers moves the ownership rise earlier or later by one edge. The vector walk detects this because it checks every cycle. The request register is checked across low-power entry with and without the hold bit, where a wrong retained value stays visible until the next change of the low-power inputs.

// File: rtl/bus_tenure_ctl.sv
module bus_tenure_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_need,
  input  logic arb_grant,
  input  logic bb_line,
  input  logic req_hold,
  input  logic stop_mode,
  input  logic wait_mode,
  output logic br_out,
  output logic bb_drive,
  output logic bb_oe,
  output logic is_master
);

  typedef enum logic [1:0] {S_SLAVE, S_OWN, S_LETGO} own_t;

  own_t state;
  logic grant_q;
  logic idle_q;
  logic br_q;
  logic low_pwr;

  assign low_pwr = stop_mode | wait_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      grant_q <= arb_grant;
      idle_q  <= bb_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       br_q <= 1'b0;
    else if (low_pwr) br_q <= req_hold ? br_q : 1'b0;
    else              br_q <= ext_need | req_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_SLAVE;
    else begin
      case (state)
        S_SLAVE: if (ext_need && grant_q && idle_q) state <= S_OWN;
        S_OWN:   if (!ext_need && !grant_q)         state <= S_LETGO;
        default:                                    state <= S_SLAVE;
      endcase
    end
  end

  assign br_out    = br_q;
  assign is_master = (state == S_OWN);
  assign bb_oe     = (state != S_SLAVE);
  assign bb_drive  = (state != S_OWN);

  a_r3_lowpwr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && !req_hold) |=> !br_out);

  a_r3_lowpwr_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && req_hold) |=> $stable(br_out));

  a_r5_take_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_master) |-> $past(grant_q && idle_q && ext_need));

  a_r6_own_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (bb_oe && !bb_drive));

  a_r7_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && (grant_q || ext_need)) |=> is_master);

  a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_master) && !is_master) |-> (bb_oe && bb_drive));

  a_r8_release_float: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bb_oe && bb_drive)) |-> !bb_oe);

endmodule

// File: tb/bus_tenure_ctl_tb.sv
module bus_tenure_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_need = 1'b0, arb_grant = 1'b0, bb_line = 1'b1;
  logic req_hold = 1'b0, stop_mode = 1'b0, wait_mode = 1'b0;
  logic br_out, bb_drive, bb_oe, is_master;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bus_tenure_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_need(ext_need), .arb_grant(arb_grant),
    .bb_line(bb_line), .req_hold(req_hold), .stop_mode(stop_mode),
    .wait_mode(wait_mode), .br_out(br_out), .bb_drive(bb_drive),
    .bb_oe(bb_oe), .is_master(is_master)
  );

  // inputs {need,grant,bb_line,hold,stop,wait}, expected {br,master,oe,drive}
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'b001000_0001, // R1 idle
    10'b101000_1001, // R1 request
    10'b110000_1001, // R5 line busy
    10'b111000_1001, // R5 sampled
    10'b111000_1110, // R5 take, R6
    10'b010000_0110, // R7 parked, R1 br drops
    10'b010000_0110, // R7 parked
    10'b110000_1110, // R7 reuse
    10'b100000_1110, // R9 grant gone
    10'b100000_1110, // R9 still owner
    10'b000000_0011, // R8 drive high
    10'b001000_0001, // R8 float
    10'b001100_1001, // R2 hold
    10'b001110_1001, // R3 stop keep
    10'b001101_1001, // R3 wait keep
    10'b001010_0001, // R3 stop drop
    10'b101010_0001, // R3 need ignored in stop
    10'b001110_0001, // R3 keep low
    10'b001000_0001  // R1 idle
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 18:           return "R1";
      2, 3, 4:            return "R5";
      5, 6, 7:            return "R7";
      8, 9:               return "R9";
      10, 11:             return "R8";
      12:                 return "R2";
      default:            return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got br/m/oe/d=%b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R4", {br_out, is_master, bb_oe, bb_drive}, 4'b0001);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {ext_need, arb_grant, bb_line, req_hold, stop_mode, wait_mode} = VEC[i][9:4];
      @(posedge clk);
      #1;
      check(tag_of(i), {br_out, is_master, bb_oe, bb_drive}, VEC[i][3:0]);
    end
    // R5: ownership appears on the second edge
    {ext_need, arb_grant, bb_line, req_hold, stop_mode, wait_mode} = 6'b111000;
    @(posedge clk); #1;
    check("R5", {br_out, is_master, bb_oe, bb_drive}, 4'b1001);
    @(posedge clk); #1;
    check("R6", {br_out, is_master, bb_oe, bb_drive}, 4'b1110);
    // R4: asynchronous reset while owner
    #1 rst_n = 1'b0;
    #0.5;
    check("R4", {br_out, is_master, bb_oe, bb_drive}, 4'b0001);
    @(posedge clk); #1;
    check("R4", {br_out, is_master, bb_oe, bb_drive}, 4'b0001);
    {ext_need, arb_grant, bb_line, req_hold, stop_mode, wait_mode} = 6'b000000;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {br_out, is_master, bb_oe, bb_drive}, 4'b0001);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule